// File: doc/BRIEF.md
# Limit-Compare System Counter-Timer

This block is a system timer. An up-counter advances by one unit on every pulse of a tick input. The clock period of the tick strobe is set outside the block, nominally 500 ns. One unit is worth 0x200 in the 32-bit register view, so the count sits in bits 30:9 of a word and bits 8:0 always read as zero. The count is compared with a programmable limit. When the next tick would bring the count onto a nonzero limit, the counter returns to zero on that tick, a sticky reached flag is latched and a level interrupt is raised. A limit of zero selects free-running mode. In that mode the counter rolls over at the top of its range and never sets the flag or the interrupt.

Software reaches the block through 32-bit word accesses. The word index is the byte address shifted right by two.
- Word 0 reads back the limit. Writing word 0 loads a new limit and restarts the count.
- Word 1 reads the count, with the reached flag in bit 31.
- Word 2 loads a new limit without disturbing the count.

A read of word 0 is how software acknowledges a match. A controller holds the reached state in three named states:
- FREE: the limit is zero.
- ARMED: the limit is nonzero and the flag is clear.
- HIT: the flag is set.

The transitions are:
- FREE/ARMED to HIT on a limit match.
- HIT to FREE/ARMED on a word-0 read, chosen by the limit value after that cycle's writes.
- FREE and ARMED to each other on any limit write, by whether the new limit is zero.

Read data is combinational and valid in the cycle `rd_en` is high. Every state change happens at the rising clock edge that ends a cycle with a strobe high.

Top module: `limit_count_timer`

## Requirements
- R1: After reset, word 0 reads 0, word 1 reads 0, `irq` is low, and the counter runs in free-running mode.
- R2: Each clock with `tick` high advances the count by one unit (0x200 in the word view). Bits 8:0 of the count always read zero. With `tick` low and no restart, the count holds.
- R3: A read of word 1 returns the count in bits 30:9 and the reached flag in bit 31.
- R4: A write to word 0 loads the limit from `wdata` bits 30:9, discarding all other bits. It restarts the count at zero and drives `irq` low, and it leaves the reached flag unchanged. It takes precedence over a `tick` in the same cycle.
- R5: A write to word 2 loads the limit from `wdata` bits 30:9 and leaves the count, the reached flag and `irq` unchanged.
- R6: With a nonzero limit, a tick that would make the count equal the limit sets the count to zero, sets the reached flag and raises `irq`. A later match keeps both set. `irq` is never high while the flag is clear.
- R7: With a zero limit, the count rolls from the top of its range minus one unit to zero, never reads the all-ones field value, and never sets the flag or `irq`. Because the comparison uses equality, a limit at or below the current count also runs to this rollover before it matches.
- R8: A read of word 0 returns the limit and clears the reached flag and `irq` at the end of that cycle. A match in the same cycle wins, and both stay set.
- R9: Writes to word 1 and to words 3 and above are ignored. Reads of word 2 and of words 3 and above return zero. Byte-address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe that advances the count by one unit |
| wr_en | input | 1 | Word write strobe |
| rd_en | input | 1 | Word read strobe |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while `rd_en` is high, zero otherwise |
| irq | output | 1 | Level interrupt, high from a limit match until acknowledged |

## Verification
The bench sweeps every limit across a narrowed count width and checks the count after each tick. A comparison off by one would return to zero a unit early or late. The bench collides a restarting limit write with a tick, and an acknowledging read with a matching tick. A wrong priority there would leave a stale count or lose an interrupt. It lowers the limit below the running count through word 2, where a design that compared with greater-or-equal would match at once instead of running to the rollover. It also confirms that a word-0 write drops `irq` but keeps bit 31 set, which a design merging the two would not do.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    // reached-state controller
    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_HIT   = 2'd2
    } tmr_state_e;

    // decoded register strobes
    typedef struct packed {
        logic rd_limit;
        logic wr_limit_rst;
        logic wr_limit_keep;
    } tmr_strobe_t;

    localparam int unsigned UNIT_LSB        = 9;
    localparam int unsigned FLAG_BIT        = 31;
    localparam int unsigned WORD_LIMIT_RST  = 0;
    localparam int unsigned WORD_COUNT      = 1;
    localparam int unsigned WORD_LIMIT_KEEP = 2;
endpackage

// File: rtl/tmr_regdec.sv
`timescale 1ns/1ps
module tmr_regdec
    import tmr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 5,
    parameter int unsigned COUNT_BITS = 22
) (
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [31:0]           wdata,
    input  logic [COUNT_BITS-1:0] limit_units,
    input  logic [COUNT_BITS-1:0] count_units,
    input  logic                  flag,
    output tmr_strobe_t           strobe,
    output logic [COUNT_BITS-1:0] wr_units,
    output logic [31:0]           rdata
);
    localparam int unsigned WORD_W = ADDR_W - 2;
    localparam int unsigned TOP_LSB = UNIT_LSB + COUNT_BITS;
    localparam logic [WORD_W-1:0] W_RST  = WORD_W'(WORD_LIMIT_RST);
    localparam logic [WORD_W-1:0] W_CNT  = WORD_W'(WORD_COUNT);
    localparam logic [WORD_W-1:0] W_KEEP = WORD_W'(WORD_LIMIT_KEEP);

    logic [WORD_W-1:0] word_idx;
    logic              unused_byte_lane;
    logic              unused_wdata_bits;

    assign word_idx          = addr[ADDR_W-1:2];
    assign unused_byte_lane  = ^addr[1:0];
    assign unused_wdata_bits = ^{wdata[31:TOP_LSB], wdata[UNIT_LSB-1:0]};
    assign wr_units          = wdata[UNIT_LSB +: COUNT_BITS];

    function automatic logic [31:0] place_units(input logic [COUNT_BITS-1:0] u);
        logic [31:0] r;
        r = '0;
        r[UNIT_LSB +: COUNT_BITS] = u;
        return r;
    endfunction

    always_comb begin
        strobe.rd_limit      = rd_en && (word_idx == W_RST);
        strobe.wr_limit_rst  = wr_en && (word_idx == W_RST);
        strobe.wr_limit_keep = wr_en && (word_idx == W_KEEP);
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (word_idx)
                W_RST: rdata = place_units(limit_units);
                W_CNT: begin
                    rdata           = place_units(count_units);
                    rdata[FLAG_BIT] = flag;
                end
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
    parameter int unsigned COUNT_BITS = 22
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  restart,
    input  logic [COUNT_BITS-1:0] limit_units,
    output logic [COUNT_BITS-1:0] count_units,
    output logic                  hit
);
    localparam logic [COUNT_BITS-1:0] MAX_UNITS = '1;
    localparam logic [COUNT_BITS-1:0] ONE_UNIT  = COUNT_BITS'(1);

    logic [COUNT_BITS-1:0] count_q;
    logic [COUNT_BITS-1:0] count_nx;
    logic [COUNT_BITS-1:0] step;
    logic                  limit_match;
    logic                  roll;

    assign step        = count_q + ONE_UNIT;
    assign limit_match = (limit_units != '0) && (step == limit_units);
    assign roll        = limit_match || (step == MAX_UNITS);
    assign hit         = tick && !restart && limit_match;
    assign count_units = count_q;

    always_comb begin
        count_nx = count_q;
        if (restart) begin
            count_nx = '0;
        end else if (tick) begin
            count_nx = roll ? '0 : step;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_nx;
        end
    end

    // R2: count holds without a tick or restart
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(count_q));
    // R4: restart lands on zero
    assert_restart_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count_q == '0));
    // R7: the all-ones field value is never shown
    assert_never_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count_q != MAX_UNITS);
endmodule

// File: rtl/tmr_ctrl.sv
`timescale 1ns/1ps
module tmr_ctrl
    import tmr_pkg::*;
#(
    parameter int unsigned COUNT_BITS = 22
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  tmr_strobe_t           strobe,
    input  logic [COUNT_BITS-1:0] wr_units,
    input  logic                  hit,
    output logic [COUNT_BITS-1:0] limit_units,
    output logic                  flag,
    output logic                  irq
);
    tmr_state_e            state_q;
    tmr_state_e            state_nx;
    tmr_state_e            mode_nx;
    logic [COUNT_BITS-1:0] limit_q;
    logic [COUNT_BITS-1:0] limit_nx;
    logic                  irq_q;

    always_comb begin
        limit_nx = limit_q;
        if (strobe.wr_limit_rst || strobe.wr_limit_keep) begin
            limit_nx = wr_units;
        end
        mode_nx = (limit_nx == '0) ? ST_FREE : ST_ARMED;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_FREE, ST_ARMED: state_nx = hit ? ST_HIT : mode_nx;
            ST_HIT: begin
                if (hit) begin
                    state_nx = ST_HIT;
                end else if (strobe.rd_limit) begin
                    state_nx = mode_nx;
                end else begin
                    state_nx = ST_HIT;
                end
            end
            default: state_nx = ST_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
            limit_q <= '0;
        end else begin
            state_q <= state_nx;
            limit_q <= limit_nx;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (hit) begin
            irq_q <= 1'b1;
        end else if (strobe.rd_limit || strobe.wr_limit_rst) begin
            irq_q <= 1'b0;
        end
    end

    assign limit_units = limit_q;
    assign flag        = (state_q == ST_HIT);
    assign irq         = irq_q;

    // R7: a match never comes from a zero limit
    assert_no_free_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (limit_q != '0));
    // R8: acknowledge clears both flag and interrupt
    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe.rd_limit && !hit) |=> (!irq_q && state_q != ST_HIT));
    // R5: keep-count write leaves the interrupt alone
    assert_keep_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe.wr_limit_keep && !strobe.rd_limit && !strobe.wr_limit_rst && !hit)
        |=> $stable(irq_q));
    // R6: a match sets the flag on the next cycle
    assert_hit_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (irq_q && state_q == ST_HIT));
endmodule

// File: rtl/limit_count_timer.sv
`timescale 1ns/1ps
module limit_count_timer
    import tmr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 5,
    parameter int unsigned COUNT_BITS = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq
);
    tmr_strobe_t           strobe;
    logic [COUNT_BITS-1:0] wr_units;
    logic [COUNT_BITS-1:0] limit_units;
    logic [COUNT_BITS-1:0] count_units;
    logic                  flag;
    logic                  hit;

    tmr_regdec #(.ADDR_W(ADDR_W), .COUNT_BITS(COUNT_BITS)) u_regdec (
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .wdata       (wdata),
        .limit_units (limit_units),
        .count_units (count_units),
        .flag        (flag),
        .strobe      (strobe),
        .wr_units    (wr_units),
        .rdata       (rdata)
    );

    tmr_counter #(.COUNT_BITS(COUNT_BITS)) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .restart     (strobe.wr_limit_rst),
        .limit_units (limit_units),
        .count_units (count_units),
        .hit         (hit)
    );

    tmr_ctrl #(.COUNT_BITS(COUNT_BITS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe      (strobe),
        .wr_units    (wr_units),
        .hit         (hit),
        .limit_units (limit_units),
        .flag        (flag),
        .irq         (irq)
    );

    // R6: interrupt implies reached flag
    assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);
    // R1: quiet after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!irq && count_units == '0));
endmodule

// File: tb/test_limit_count_timer.sv
`timescale 1ns/1ps
module test_limit_count_timer;
    localparam int AW = 5;
    localparam int CB = 6;
    localparam int TOPU = (1 << CB) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;

    int  tests = 0;
    int  fails = 0;
    bit  done = 1'b0;
    logic [31:0] v;

    always #5 clk = ~clk;

    limit_count_timer #(.ADDR_W(AW), .COUNT_BITS(CB)) i_limit_count_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    function automatic logic [31:0] u(input int n);
        return 32'(n) << 9;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr_b(input int b, input logic [31:0] d);
        wr_en = 1'b1; addr = AW'(b); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_b(input int b, output logic [31:0] d);
        rd_en = 1'b1; addr = AW'(b);
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", 32'(irq), 0);
        rd_b(0, v); check("R1 limit", v, 0);
        rd_b(4, v); check("R1 count", v, 0);

        // R2 R7 free-run sweep
        for (int i = 1; i < TOPU; i++) begin
            ticks(1);
            rd_b(4, v); check("R2 free count", v, u(i));
        end
        repeat (4) @(negedge clk);
        rd_b(4, v); check("R2 hold", v, u(TOPU - 1));
        ticks(1);
        rd_b(4, v); check("R7 rollover", v, 0);
        check("R7 no irq", 32'(irq), 0);

        // R6 R3 R8 every limit
        for (int l = 1; l <= TOPU; l++) begin
            wr_b(0, u(l));
            rd_b(4, v); check("R4 restart", v, 0);
            for (int k = 1; k < l; k++) begin
                ticks(1);
                rd_b(4, v); check("R6 count", v, u(k));
            end
            ticks(1);
            rd_b(4, v); check("R3 flag in bit31", v, 32'h8000_0000);
            check("R6 irq", 32'(irq), 1);
            rd_b(0, v); check("R8 limit read", v, u(l));
            check("R8 irq cleared", 32'(irq), 0);
            rd_b(4, v); check("R8 flag cleared", v, 0);
        end

        // R6 repeated match; R4 write keeps flag
        wr_b(0, u(3));
        ticks(6);
        rd_b(4, v); check("R6 second match", v, 32'h8000_0000);
        check("R6 irq held", 32'(irq), 1);
        wr_b(0, u(4));
        check("R4 irq low", 32'(irq), 0);
        rd_b(4, v); check("R4 flag kept", v, 32'h8000_0000);
        rd_b(0, v); check("R8 ack", v, u(4));
        rd_b(4, v); check("R8 clean", v, 0);

        // R5 keep-count limit write
        wr_b(0, u(10));
        ticks(3);
        wr_b(8, u(5));
        rd_b(4, v); check("R5 count kept", v, u(3));
        rd_b(0, v); check("R5 limit", v, u(5));
        ticks(1);
        rd_b(4, v); check("R5 count", v, u(4));
        ticks(1);
        rd_b(4, v); check("R5 match new limit", v, 32'h8000_0000);
        wr_b(8, u(7));
        check("R5 irq kept", 32'(irq), 1);
        rd_b(4, v); check("R5 flag kept", v, 32'h8000_0000);
        rd_b(0, v); check("R5 limit 7", v, u(7));
        check("R8 irq low", 32'(irq), 0);

        // R7 limit below count runs to rollover
        ticks(3);
        wr_b(8, u(2));
        ticks(TOPU - 4);
        rd_b(4, v); check("R7 passes low limit", v, u(TOPU - 1));
        check("R7 irq low", 32'(irq), 0);
        ticks(1);
        rd_b(4, v); check("R7 wrap", v, 0);
        ticks(2);
        rd_b(4, v); check("R6 match after wrap", v, 32'h8000_0000);
        rd_b(0, v);

        // R4 write beats tick
        wr_b(0, u(5));
        ticks(2);
        wr_en = 1'b1; addr = '0; wdata = u(6); tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        rd_b(4, v); check("R4 write over tick", v, 0);
        ticks(5);
        rd_b(4, v); check("R4 new limit", v, u(5));
        ticks(1);
        check("R4 new limit match", 32'(irq), 1);
        rd_b(0, v);

        // R8 match beats acknowledge
        wr_b(0, u(4));
        ticks(3);
        rd_en = 1'b1; addr = '0; tick = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0; tick = 1'b0;
        check("R8 read during match", v, u(4));
        check("R8 match wins irq", 32'(irq), 1);
        rd_b(4, v); check("R8 match wins flag", v, 32'h8000_0000);
        rd_b(0, v);

        // R9 ignored words
        wr_b(0, u(6));
        ticks(2);
        wr_b(4, 32'hFFFF_FE00);
        rd_b(4, v); check("R9 word1 write ignored", v, u(2));
        rd_b(8, v); check("R9 word2 read zero", v, 0);
        for (int w = 3; w < 8; w++) begin
            rd_b(w * 4, v); check("R9 high read zero", v, 0);
            wr_b(w * 4, 32'hFFFF_FFFF);
        end
        rd_b(7, v); check("R9 byte lane count", v, u(2));
        rd_b(1, v); check("R9 byte lane limit", v, u(6));
        check("R9 irq", 32'(irq), 0);

        // R4 masking and zero limit
        wr_b(0, 32'hFFFF_FFFF);
        rd_b(0, v); check("R4 mask", v, u(TOPU));
        wr_b(0, 32'h0000_01FF);
        rd_b(0, v); check("R4 low bits dropped", v, 0);
        ticks(TOPU);
        rd_b(4, v); check("R7 zero limit wrap", v, 0);
        check("R7 zero limit irq", 32'(irq), 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule